// File: doc/BRIEF.md
# Sleep Entry Link Shutdown Sequencer

This block runs the link side of entry into a deep system sleep state: suspend-to-RAM, suspend-to-disk or soft-off. Software writes a sleep kind into a control register over a simple valid/ready write channel. The block answers every accepted write with a completion and holds that completion until the requester takes it. Only after the requester has taken the completion for a write that asked for sleep does the sequencer tell the serial link ports to shut down. It pulses a one-cycle turn-off strobe to each enabled port. It does this whatever state each link is in at that moment, whether fully active or already in a light low-power state.

After the strobes, the block watches a two-bit link-state code from every port. A port counts as finished once its code has shown the off-ready state at any point during the wait. Ports whose enable input is low have no link and are left out of the check. When every enabled port has finished, the sequencer asserts a proceed output and presents the requested sleep kind. It then holds both so that the rest of sleep entry can continue. Downstream acknowledge messages play no part in this sequence; only the link-state code matters. If some link never reports off-ready, a programmable wait limit ends the wait: proceed is still raised, and a timeout flag is set alongside it. A wake input returns the sequencer to idle from any state.

Top module: `slp_link_quiesce_seq`

## Requirements
- R1: A write is accepted in a cycle where `wr_valid` and `wr_ready` are both high. `cpl_valid` goes high on the next cycle and stays high until a cycle with `cpl_ready` high. `wr_ready` is low exactly while a completion is pending.
- R2: `wr_type` encodes 2'b01 suspend-to-RAM, 2'b10 suspend-to-disk and 2'b11 soft-off. A write of 2'b00, and any write accepted while a sequence is in progress or finished, is still completed but starts nothing: no turn-off strobe and no proceed.
- R3: No turn-off strobe appears before the completion handshake of the starting write. The strobes appear two clock edges after that handshake edge, are one cycle wide, and occur once per sleep request.
- R4: The turn-off strobe is issued whatever the current link-state code of the port (00 active, 01 light low-power, or any other value).
- R5: Link-state code 2'b10 means off-ready. `sleep_proceed` rises on the clock edge at which every enabled port has shown code 2'b10 at least once since the strobes. A port that shows 2'b10 and then leaves it still counts as ready.
- R6: Turn-off strobes go only to ports with `port_en` high. Ports with `port_en` low are ignored by the ready check. With no port enabled, proceed rises on the first cycle of the wait.
- R7: If not every enabled port is ready, the sequencer waits `wait_limit`+1 cycles counted from the strobe edge. It then raises `sleep_proceed` and `ready_timeout` together. `ready_timeout` is never high without `sleep_proceed`.
- R8: `wake` high at a clock edge returns the sequencer to idle. It clears `sleep_proceed`, `ready_timeout`, `sleep_kind` and any strobe not yet issued. A pending completion is not affected.
- R9: After reset every output is 0 except `wr_ready`, which is 1. While `sleep_proceed` is high, `sleep_kind` shows the kind of the write that started the sequence, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Control register write request |
| wr_type | input | 2 | Requested sleep kind carried by the write |
| wr_ready | output | 1 | Write can be accepted |
| cpl_valid | output | 1 | Write completion pending toward the requester |
| cpl_ready | input | 1 | Requester takes the completion |
| port_en | input | NPORTS | Per-port enable; low masks the port out |
| link_state | input | 2*NPORTS | Two-bit link-state code per port, port g at bits [2g+1:2g] |
| wake | input | 1 | Return to idle |
| wait_limit | input | CNT_W | Wait bound for the all-ready check |
| turnoff_strobe | output | NPORTS | One-cycle turn-off request per port |
| sleep_proceed | output | 1 | Link shutdown finished; continue sleep entry |
| sleep_kind | output | 2 | Sleep kind being entered |
| ready_timeout | output | 1 | Proceed was forced by the wait limit |

## Verification
The hardest case to reach is a link that passes through off-ready and leaves it again before the other ports finish. The sequencer must remember the earlier report and still proceed. The bench sets up this case by holding one port at code 2'b10 for a single cycle and then moving it back to the light low-power code while the others are still active. It then raises the rest later. The other case is the wake path: wake is raised mid-wait and again while the completion is still pending, and the bench confirms that no strobe or proceed leaks out afterwards.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;

  localparam int LINK_W = 2;
  localparam int KIND_W = 2;

  localparam logic [LINK_W-1:0] LINK_OFF_READY = 2'b10;
  localparam logic [KIND_W-1:0] KIND_NONE      = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CPL,
    ST_SEND,
    ST_WAIT_RDY,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/slp_ctl_port.sv
module slp_ctl_port
  import slp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [KIND_W-1:0] wr_type,
  input  logic              cpl_ready,
  output logic              wr_ready,
  output logic              cpl_valid,
  output logic              wr_fire,
  output logic              cpl_fire,
  output logic [KIND_W-1:0] fire_kind
);

  logic cpl_pend_q;

  // one completion outstanding at a time; a new write waits for it
  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_pend_q <= 1'b0;
    end else if (cpl_pend_q) begin
      if (cpl_ready) cpl_pend_q <= 1'b0;
    end else if (wr_valid) begin
      cpl_pend_q <= 1'b1;
    end
  end

  assign wr_ready  = ~cpl_pend_q;
  assign cpl_valid = cpl_pend_q;
  assign wr_fire   = wr_valid & ~cpl_pend_q;
  assign cpl_fire  = cpl_pend_q & cpl_ready;
  assign fire_kind = wr_type;

endmodule

// File: rtl/slp_port_track.sv
module slp_port_track
  import slp_seq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue,
  input  logic                     watch,
  input  logic [NPORTS-1:0]        port_en,
  input  logic [NPORTS*LINK_W-1:0] link_state,
  output logic [NPORTS-1:0]        turnoff,
  output logic                     all_ready
);

  logic [NPORTS-1:0] seen_q;
  logic [NPORTS-1:0] rdy_now;
  logic [NPORTS-1:0] port_ok;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign rdy_now[g] = (link_state[g*LINK_W +: LINK_W] == LINK_OFF_READY);

    // sticky: a link that touched off-ready keeps counting as done
    always_ff @(posedge clk) begin
      if (rst || !watch) seen_q[g] <= 1'b0;
      else if (rdy_now[g]) seen_q[g] <= 1'b1;
    end

    // strobe does not look at the link code at all
    always_ff @(posedge clk) begin
      if (rst) turnoff[g] <= 1'b0;
      else     turnoff[g] <= issue & port_en[g];
    end

    assign port_ok[g] = ~port_en[g] | seen_q[g] | rdy_now[g];
  end

  assign all_ready = &port_ok;

endmodule

// File: rtl/slp_wait_timer.sv
module slp_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/slp_link_quiesce_seq.sv
module slp_link_quiesce_seq
  import slp_seq_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  input  logic [1:0]               wr_type,
  output logic                     wr_ready,
  output logic                     cpl_valid,
  input  logic                     cpl_ready,
  input  logic [NPORTS-1:0]        port_en,
  input  logic [2*NPORTS-1:0]      link_state,
  input  logic                     wake,
  input  logic [CNT_W-1:0]         wait_limit,
  output logic [NPORTS-1:0]        turnoff_strobe,
  output logic                     sleep_proceed,
  output logic [1:0]               sleep_kind,
  output logic                     ready_timeout
);

  seq_state_t        state_q;
  logic [KIND_W-1:0] kind_q;
  logic              wr_fire;
  logic              cpl_fire;
  logic [KIND_W-1:0] fire_kind;
  logic              all_ready;
  logic              expired;
  logic              issue;
  logic              watch;

  slp_ctl_port u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_type   (wr_type),
    .cpl_ready (cpl_ready),
    .wr_ready  (wr_ready),
    .cpl_valid (cpl_valid),
    .wr_fire   (wr_fire),
    .cpl_fire  (cpl_fire),
    .fire_kind (fire_kind)
  );

  assign issue = (state_q == ST_SEND) & ~wake;
  assign watch = (state_q == ST_WAIT_RDY);

  slp_port_track #(.NPORTS(NPORTS)) u_track (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .watch      (watch),
    .port_en    (port_en),
    .link_state (link_state),
    .turnoff    (turnoff_strobe),
    .all_ready  (all_ready)
  );

  slp_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (watch),
    .limit   (wait_limit),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      kind_q        <= KIND_NONE;
      sleep_proceed <= 1'b0;
      sleep_kind    <= KIND_NONE;
      ready_timeout <= 1'b0;
    end else if (wake) begin
      state_q       <= ST_IDLE;
      sleep_proceed <= 1'b0;
      sleep_kind    <= KIND_NONE;
      ready_timeout <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_fire && fire_kind != KIND_NONE) begin
            state_q <= ST_WAIT_CPL;
            kind_q  <= fire_kind;
          end
        end
        ST_WAIT_CPL: begin
          if (cpl_fire) state_q <= ST_SEND;
        end
        ST_SEND: begin
          state_q <= ST_WAIT_RDY;
        end
        ST_WAIT_RDY: begin
          if (all_ready || expired) begin
            state_q       <= ST_DONE;
            sleep_proceed <= 1'b1;
            sleep_kind    <= kind_q;
            ready_timeout <= ~all_ready;
          end
        end
        ST_DONE: begin
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/slp_seq_checker.sv
module slp_seq_checker #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic              wake,
  input logic [NPORTS-1:0] turnoff_strobe,
  input logic              sleep_proceed,
  input logic              ready_timeout
);

  assert_cpl_follows_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> cpl_valid);

  assert_cpl_held_R1: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !cpl_ready) |=> cpl_valid);

  assert_strobe_after_cpl_R3: assert property (@(posedge clk) disable iff (rst)
    (|turnoff_strobe) |-> $past(cpl_valid && cpl_ready, 2));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    (|turnoff_strobe) |=> (turnoff_strobe == '0));

  assert_proceed_held_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_proceed) |-> $past(wake));

  assert_timeout_with_proceed_R7: assert property (@(posedge clk) disable iff (rst)
    ready_timeout |-> sleep_proceed);

  assert_wake_clears_R8: assert property (@(posedge clk) disable iff (rst)
    wake |=> (!sleep_proceed && !ready_timeout && turnoff_strobe == '0));

endmodule

bind slp_link_quiesce_seq slp_seq_checker #(.NPORTS(NPORTS)) u_seq_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_valid       (wr_valid),
  .wr_ready       (wr_ready),
  .cpl_valid      (cpl_valid),
  .cpl_ready      (cpl_ready),
  .wake           (wake),
  .turnoff_strobe (turnoff_strobe),
  .sleep_proceed  (sleep_proceed),
  .ready_timeout  (ready_timeout)
);

// File: tb/slp_link_quiesce_seq_test.sv
module slp_link_quiesce_seq_test;

  localparam int NP = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [1:0]    wr_type = 2'b00;
  logic          wr_ready;
  logic          cpl_valid;
  logic          cpl_ready = 1'b0;
  logic [NP-1:0] port_en = '1;
  logic [2*NP-1:0] link_state = '0;
  logic          wake = 1'b0;
  logic [CW-1:0] wait_limit = 16'd1000;
  logic [NP-1:0] turnoff_strobe;
  logic          sleep_proceed;
  logic [1:0]    sleep_kind;
  logic          ready_timeout;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  slp_link_quiesce_seq #(.NPORTS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_type(wr_type),
    .wr_ready(wr_ready), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .port_en(port_en), .link_state(link_state), .wake(wake),
    .wait_limit(wait_limit), .turnoff_strobe(turnoff_strobe),
    .sleep_proceed(sleep_proceed), .sleep_kind(sleep_kind),
    .ready_timeout(ready_timeout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase = 0;           // 0 idle,1 wait cpl,2 send,3 wait ready,4 done
  bit m_cpl = 0;
  int m_tof = 0;
  bit m_go = 0;
  bit m_to = 0;
  int m_kind = 0;
  int m_kind_out = 0;
  int m_cnt = 0;
  bit m_seen[NP];

  always @(posedge clk) begin
    bit acc, hs, allok;
    int nxt_cpl;
    acc = wr_valid && !m_cpl;
    hs  = m_cpl && cpl_ready;
    nxt_cpl = hs ? 0 : (m_cpl ? 1 : int'(wr_valid));
    if (rst) begin
      m_phase = 0; m_tof = 0; m_go = 0; m_to = 0; m_kind = 0; m_kind_out = 0;
      m_cnt = 0; nxt_cpl = 0;
      foreach (m_seen[i]) m_seen[i] = 0;
    end else if (wake) begin
      m_phase = 0; m_tof = 0; m_go = 0; m_to = 0; m_kind_out = 0; m_cnt = 0;
      foreach (m_seen[i]) m_seen[i] = 0;
    end else begin
      m_tof = 0;
      case (m_phase)
        0: if (acc && wr_type != 0) begin m_phase = 1; m_kind = wr_type; end
        1: if (hs) m_phase = 2;
        2: begin
          m_tof = port_en; m_phase = 3; m_cnt = 0;
          foreach (m_seen[i]) m_seen[i] = 0;
        end
        3: begin
          allok = 1;
          for (int i = 0; i < NP; i++) begin
            if (link_state[2*i +: 2] == 2'b10) m_seen[i] = 1;
            if (port_en[i] && !m_seen[i]) allok = 0;
          end
          if (allok) begin
            m_phase = 4; m_go = 1; m_kind_out = m_kind;
          end else if (m_cnt == int'(wait_limit)) begin
            m_phase = 4; m_go = 1; m_to = 1; m_kind_out = m_kind;
          end else begin
            m_cnt++;
          end
        end
        default: ;
      endcase
    end
    m_cpl = nxt_cpl[0];
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(cpl_valid == m_cpl, "R1 cpl_valid", cpl_valid, m_cpl);
      chk(wr_ready == !m_cpl, "R1 wr_ready", wr_ready, !m_cpl);
      chk(int'(turnoff_strobe) == m_tof, "R3 turnoff_strobe", turnoff_strobe, m_tof);
      chk(sleep_proceed == m_go, "R5 sleep_proceed", sleep_proceed, m_go);
      chk(ready_timeout == m_to, "R7 ready_timeout", ready_timeout, m_to);
      chk(int'(sleep_kind) == m_kind_out, "R9 sleep_kind", sleep_kind, m_kind_out);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic write_kind(input logic [1:0] k);
    @(negedge clk); wr_valid = 1'b1; wr_type = k;
    @(negedge clk); wr_valid = 1'b0; wr_type = 2'b00;
  endtask

  task automatic take_cpl();
    cpl_ready = 1'b1;
    @(negedge clk); cpl_ready = 1'b0;
  endtask

  task automatic set_link(input int p, input logic [1:0] code);
    link_state[2*p +: 2] = code;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(wr_ready == 1 && cpl_valid == 0 && turnoff_strobe == 0 && sleep_proceed == 0
        && sleep_kind == 0 && ready_timeout == 0, "R9 reset outputs", 0, 0);

    // ---- suspend-to-RAM, links mixed active / light low-power (R3, R4, R5)
    set_link(0, 2'b01); set_link(1, 2'b00); set_link(2, 2'b01); set_link(3, 2'b11);
    write_kind(2'b01);
    repeat (3) @(negedge clk);
    chk(cpl_valid == 1 && turnoff_strobe == 0, "R3 no strobe before completion", turnoff_strobe, 0);
    take_cpl();                       // handshake edge happened
    @(negedge clk);
    chk(turnoff_strobe == 4'b1111, "R4 strobe regardless of link code", turnoff_strobe, 15);
    @(negedge clk);
    chk(turnoff_strobe == 0, "R3 strobe one cycle wide", turnoff_strobe, 0);
    set_link(0, 2'b10);
    @(negedge clk); set_link(0, 2'b01);   // transient off-ready on port 0
    set_link(1, 2'b10);
    repeat (2) @(negedge clk);
    set_link(2, 2'b10);
    @(negedge clk);
    chk(sleep_proceed == 0, "R5 not yet all ready", sleep_proceed, 0);
    set_link(3, 2'b10);
    @(negedge clk);
    chk(sleep_proceed == 1 && sleep_kind == 2'b01, "R5 sticky ready proceed", sleep_proceed, 1);
    // R2 write while done is completed but ignored
    write_kind(2'b11);
    take_cpl();
    repeat (3) @(negedge clk);
    chk(turnoff_strobe == 0 && sleep_kind == 2'b01, "R2 write while done ignored", sleep_kind, 1);
    pulse_wake();
    chk(sleep_proceed == 0 && sleep_kind == 0, "R8 wake clears proceed", sleep_proceed, 0);

    // ---- kind 00 starts nothing (R2)
    link_state = '0;
    write_kind(2'b00);
    take_cpl();
    repeat (4) @(negedge clk);
    chk(turnoff_strobe == 0 && sleep_proceed == 0, "R2 null kind ignored", sleep_proceed, 0);

    // ---- masked ports, suspend-to-disk (R6)
    port_en = 4'b0101;
    write_kind(2'b10);
    take_cpl();
    @(negedge clk);
    chk(turnoff_strobe == 4'b0101, "R6 strobe only enabled ports", turnoff_strobe, 5);
    set_link(0, 2'b10); set_link(2, 2'b10);
    @(negedge clk);
    @(negedge clk);
    chk(sleep_proceed == 1 && sleep_kind == 2'b10 && ready_timeout == 0,
        "R6 masked ports ignored", sleep_proceed, 1);
    pulse_wake();

    // ---- nothing enabled: immediate proceed (R6)
    port_en = '0; link_state = '0;
    write_kind(2'b11);
    take_cpl();
    @(negedge clk);
    chk(turnoff_strobe == 0, "R6 no enabled port strobe", turnoff_strobe, 0);
    @(negedge clk);
    chk(sleep_proceed == 1 && sleep_kind == 2'b11, "R6 empty mask proceed", sleep_proceed, 1);
    pulse_wake();

    // ---- timeout (R7)
    port_en = '1; wait_limit = 16'd5; link_state = '0;
    write_kind(2'b01);
    take_cpl();
    @(negedge clk);
    chk(turnoff_strobe == 4'b1111, "R7 strobe before wait", turnoff_strobe, 15);
    repeat (5) @(negedge clk);
    chk(sleep_proceed == 0, "R7 no proceed before limit", sleep_proceed, 0);
    @(negedge clk);
    chk(sleep_proceed == 1 && ready_timeout == 1, "R7 timeout proceed", ready_timeout, 1);
    pulse_wake();
    chk(ready_timeout == 0, "R8 wake clears timeout", ready_timeout, 0);

    // ---- wake in the middle of the wait (R8)
    wait_limit = 16'd1000;
    write_kind(2'b10);
    take_cpl();
    repeat (3) @(negedge clk);
    pulse_wake();
    link_state = {NP{2'b10}};
    repeat (4) @(negedge clk);
    chk(sleep_proceed == 0 && turnoff_strobe == 0, "R8 wake mid wait", sleep_proceed, 0);

    // ---- wake while completion pending (R8, R1)
    link_state = '0;
    write_kind(2'b11);
    pulse_wake();
    chk(cpl_valid == 1, "R8 completion survives wake", cpl_valid, 1);
    take_cpl();
    repeat (4) @(negedge clk);
    chk(turnoff_strobe == 0 && sleep_proceed == 0, "R8 no strobe after aborted start",
        turnoff_strobe, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule